// File: doc/BRIEF.md
# Double-Buffered Ten-Bit Pulse-Width Generator

This block drives one pulse-width modulated output from an 8-bit period timer. The timer advances behind a selectable divider, and two sub-step bits taken from that divider extend the time base to 10 bits. The frame length comes from an 8-bit period value. The high time comes from a 10-bit duty word, split into an 8-bit upper part and a 2-bit lower part.

The duty word is not compared directly. It is copied into a shadow register at each frame boundary. A write that lands in the middle of a frame therefore never produces a runt or stretched pulse. A duty of zero keeps the line low for the whole frame. A duty at or beyond the frame length keeps it high for the whole frame. A mode enable parks the block: the output goes low, and the first enabled step afterwards opens a fresh frame.

Top module: `pwm10_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `pwm_out`=0, `period_match`=0 and `timer_val`=0.
- R2: With `pwm_en` and `clk_en` held high, every frame lasts (N+1)*4*P clocks, where N is `period` and P is the divide ratio. `period_match` is high for exactly one cycle at the start of each frame.
- R3: The divide ratio P is set by `pre_sel`: code 0 selects 1, code 1 selects 4, and codes 2 and 3 both select 16.
- R4: The duty word D is {`duty_hi`, `duty_lo`}, with `duty_lo` as bits 1:0. For 1 <= D < 4*(N+1), `pwm_out` is high for the first D*P clocks of the frame and low for the rest.
- R5: With D = 0, `pwm_out` stays low for the entire frame.
- R6: With D >= 4*(N+1), `pwm_out` stays high for the entire frame.
- R7: A change of `duty_hi`/`duty_lo` during a frame does not alter that frame. The new value governs the following frame.
- R8: While `pwm_en` is low, `pwm_out` and `period_match` are 0 and `timer_val` equals `period`. The first clock with `pwm_en` and `clk_en` both high starts a frame: in the next cycle `period_match`=1, `timer_val`=0, and `pwm_out`=1 if D is non-zero.
- R9: A clock with `clk_en` low changes neither `timer_val` nor `pwm_out`, and does not count toward the frame length.
- R10: Within a frame, clock k (k=0 at the `period_match` cycle) shows `timer_val` = k / (4*P), using integer division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; one time-base sub-step per enabled clock |
| pwm_en | input | 1 | Mode enable; low parks the block with the output low |
| period | input | 8 | Last timer value of a frame (N) |
| duty_hi | input | 8 | Upper eight bits of the duty word |
| duty_lo | input | 2 | Lower two bits of the duty word |
| pre_sel | input | 2 | Divide-ratio select (0: 1, 1: 4, 2 and 3: 16) |
| pwm_out | output | 1 | Modulated output |
| period_match | output | 1 | One-cycle pulse at each frame start |
| timer_val | output | 8 | Current period-timer value |

## Verification
The bench sweeps every duty word from zero to two past the frame length, for period values 0 to 3 and for all four divider codes. It also covers a 255-period frame at its edge values. Each frame's length, high time and timer staircase are compared with closed-form values. The sweep separates the zero-duty, proportional and saturated regions, and it shows whether codes 2 and 3 truly alias. Separate sequences write the duty mid-frame, freeze the clock enable inside a pulse, and park and restart the block. These show that the shadow register, the hold behaviour and the restart each act only at their intended cycle.

// File: rtl/pwm10_pkg.sv
// Package: shared helpers for the ten-bit pulse-width generator.
// Assumes divider stages are powers of four, indexed from zero.
package pwm10_pkg;

    // Map a divider select code onto a stage index; codes past the last stage alias to it.
    function automatic int unsigned stage_of(input int unsigned code, input int unsigned stages);
        return (code >= stages) ? stages - 1 : code;
    endfunction

endpackage

// File: rtl/pwm10_prescaler.sv
// Module: sub-step divider. It counts enabled clocks within one timer step and
// provides the step-end strobe and the two sub-step bits of the extended time base.
// Assumes: stage g divides by 4^(g+1) enabled clocks per timer step.
// While parked, the counter sits at its limit, so the first enabled clock ends a step.
module pwm10_prescaler
    import pwm10_pkg::*;
#(
    parameter int FRAC_W    = 2,
    parameter int PS_STAGES = 3,
    parameter int SEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clk_en,
    input  logic [SEL_W-1:0]  sel,
    output logic              step_last,
    output logic [FRAC_W-1:0] frac
);
    localparam int DIV_W = FRAC_W * PS_STAGES;

    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  lim_tab  [PS_STAGES];
    logic [FRAC_W-1:0] frac_tab [PS_STAGES];
    logic [DIV_W-1:0]  limit;
    int unsigned       stage;

    // One limit and one sub-step slice per divider stage.
    for (genvar g = 0; g < PS_STAGES; g++) begin : g_stage
        assign lim_tab[g]  = DIV_W'((1 << (FRAC_W * (g + 1))) - 1);
        assign frac_tab[g] = div_q[FRAC_W*g +: FRAC_W];
    end

    // Select the active stage from the select code.
    always_comb begin
        stage = stage_of(int'(sel), PS_STAGES);
        limit = lim_tab[stage];
        frac  = frac_tab[stage];
    end

    assign step_last = en && clk_en && (div_q >= limit);

    // Advance the sub-step counter, restart at the limit, park at the limit when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)          div_q <= '0;
        else if (!en)        div_q <= limit;
        else if (step_last)  div_q <= '0;
        else if (clk_en)     div_q <= div_q + 1'b1;
    end

    // R3: the counter restarts after every step end.
    a_r3_step_restart: assert property (@(posedge clk) disable iff (!rst_n)
        step_last |=> (div_q == '0));
    // R9: a disabled clock leaves the divider untouched.
    a_r9_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clk_en) |=> $stable(div_q));
endmodule

// File: rtl/pwm10_timebase.sv
// Module: 8-bit period timer. It advances on each divider step end and wraps
// after reaching the period value. The wrap strobe marks the frame boundary.
// Assumes: while parked, the timer holds the period value, so the next step wraps.
module pwm10_timebase #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step_last,
    input  logic [TMR_W-1:0] period,
    output logic [TMR_W-1:0] timer_q,
    output logic             wrap,
    output logic             match_q
);
    assign wrap = step_last && (timer_q == period);

    // Count timer steps, clear on wrap, hold at the period when parked.
    always_ff @(posedge clk) begin
        if (!rst_n)         timer_q <= '0;
        else if (!en)       timer_q <= period;
        else if (wrap)      timer_q <= '0;
        else if (step_last) timer_q <= timer_q + 1'b1;
    end

    // Register a one-cycle frame-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= wrap;
    end

    // R2: a wrap opens a frame at timer zero with the match pulse raised.
    a_r2_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (timer_q == '0) && match_q);
    // R9: the timer only moves on a step end or while parked.
    a_r9_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step_last) |=> $stable(timer_q));
endmodule

// File: rtl/pwm10_duty.sv
// Module: duty shadow and output set/reset latch. The shadow takes the duty word
// only at a wrap. The latch is set at a wrap when the new word is non-zero, and
// cleared once the extended time base equals the shadow.
// Assumes: wrap is a single-cycle strobe from the timebase.
module pwm10_duty #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wrap,
    input  logic [W-1:0] duty_in,
    input  logic [W-1:0] tb,
    output logic         pwm_out
);
    logic [W-1:0] shadow_q;
    logic         latch_q;
    logic         hit;

    assign hit = (tb == shadow_q);

    // Capture the duty word only on a frame boundary; clear while parked.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) shadow_q <= '0;
        else if (wrap)     shadow_q <= duty_in;
    end

    // Set/reset latch: set wins at the boundary, reset on time-base match.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) latch_q <= 1'b0;
        else if (wrap)     latch_q <= |duty_in;
        else if (hit)      latch_q <= 1'b0;
    end

    // Drop the line in the very cycle the time base reaches the shadow.
    assign pwm_out = latch_q && !hit;

    // R7: the shadow changes only at a wrap.
    a_r7_shadow_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> $stable(shadow_q));
    // R5: a zero word at the boundary keeps the output low.
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap && (duty_in == '0)) |=> !pwm_out);
    // R8: parking forces the output low.
    a_r8_park_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);
endmodule

// File: rtl/pwm10_gen.sv
// Module: top of the ten-bit pulse-width generator. It joins the divider, the
// period timer and the duty latch. The extended time base is {timer, sub-step bits}.
// Assumes: the period is not lowered below the running timer value mid-frame.
module pwm10_gen #(
    parameter int TMR_W     = 8,
    parameter int FRAC_W    = 2,
    parameter int PS_STAGES = 3,
    parameter int SEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              pwm_en,
    input  logic [TMR_W-1:0]  period,
    input  logic [TMR_W-1:0]  duty_hi,
    input  logic [FRAC_W-1:0] duty_lo,
    input  logic [SEL_W-1:0]  pre_sel,
    output logic              pwm_out,
    output logic              period_match,
    output logic [TMR_W-1:0]  timer_val
);
    localparam int TB_W = TMR_W + FRAC_W;

    logic              step_last;
    logic [FRAC_W-1:0] frac;
    logic              wrap;
    logic [TB_W-1:0]   tb;

    pwm10_prescaler #(.FRAC_W(FRAC_W), .PS_STAGES(PS_STAGES), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(pwm_en), .clk_en(clk_en),
        .sel(pre_sel), .step_last(step_last), .frac(frac)
    );

    pwm10_timebase #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(pwm_en), .step_last(step_last),
        .period(period), .timer_q(timer_val), .wrap(wrap), .match_q(period_match)
    );

    assign tb = {timer_val, frac};

    pwm10_duty #(.W(TB_W)) u_duty (
        .clk(clk), .rst_n(rst_n), .en(pwm_en), .wrap(wrap),
        .duty_in({duty_hi, duty_lo}), .tb(tb), .pwm_out(pwm_out)
    );

    // R2: the match pulse never lasts two cycles while running.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (period_match && clk_en && pwm_en) |=> !period_match);
    // R10: a frame start always shows timer zero.
    a_r10_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        period_match |-> (timer_val == '0));
endmodule

// File: tb/pwm10_gen_test.sv
module pwm10_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       pwm_en = 1'b0;
    logic [7:0] period = 8'd0;
    logic [7:0] duty_hi = 8'd0;
    logic [1:0] duty_lo = 2'd0;
    logic [1:0] pre_sel = 2'd0;
    logic       pwm_out;
    logic       period_match;
    logic [7:0] timer_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwm10_gen uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pwm_en(pwm_en),
        .period(period), .duty_hi(duty_hi), .duty_lo(duty_lo), .pre_sel(pre_sel),
        .pwm_out(pwm_out), .period_match(period_match), .timer_val(timer_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
    endfunction

    task automatic set_duty(input int d);
        duty_hi = 8'(d >> 2);
        duty_lo = 2'(d & 3);
    endtask

    // Park for one clock, then enable; returns at the first frame cycle.
    task automatic restart();
        pwm_en = 1'b0;
        @(negedge clk);
        chk("R8 park output", int'(pwm_out), 0);
        chk("R8 park timer", int'(timer_val), int'(period));
        pwm_en = 1'b1;
        @(negedge clk);
        chk("R8 restart match", int'(period_match), 1);
    endtask

    // Called at a period_match cycle; measures that frame up to the next match.
    task automatic measure(input int p, output int len, output int high, output int tbad);
        int k = 0;
        high = 0;
        tbad = 0;
        do begin
            if (pwm_out) high++;
            if (int'(timer_val) != k / (4 * p)) tbad++;
            @(negedge clk);
            k++;
        end while (!period_match && k < 20000);
        len = k;
    endtask

    task automatic one_frame(input int n, input int sel, input int d);
        int p = ratio(sel);
        int len, high, tbad, exph;
        period = 8'(n);
        pre_sel = 2'(sel);
        set_duty(d);
        restart();
        chk("R8 restart level", int'(pwm_out), (d != 0) ? 1 : 0);
        measure(p, len, high, tbad);
        exph = ((d < 4 * (n + 1)) ? d : 4 * (n + 1)) * p;
        chk((sel == 3) ? "R3 frame length" : "R2 frame length", len, (n + 1) * 4 * p);
        if (d == 0)                chk("R5 zero duty high", high, 0);
        else if (d >= 4 * (n + 1)) chk("R6 full duty high", high, exph);
        else                       chk("R4 high time", high, exph);
        chk("R10 timer steps", tbad, 0);
    endtask

    initial begin
        int len, high, tbad, t0, o0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset out", int'(pwm_out), 0);
        chk("R1 reset match", int'(period_match), 0);
        chk("R1 reset timer", int'(timer_val), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int sel = 0; sel < 4; sel++)
            for (int n = 0; n < 4; n++)
                for (int d = 0; d <= 4 * (n + 1) + 1; d++)
                    one_frame(n, sel, d);

        one_frame(255, 0, 0);
        one_frame(255, 0, 1);
        one_frame(255, 0, 513);
        one_frame(255, 0, 1023);
        one_frame(200, 1, 1023);

        // R7: a mid-frame write affects only the next frame.
        period = 8'd3; pre_sel = 2'd0; set_duty(5);
        restart();
        set_duty(12);
        measure(1, len, high, tbad);
        chk("R7 old duty kept", high, 5);
        measure(1, len, high, tbad);
        chk("R7 new duty next", high, 12);

        // R9: a frozen clock enable holds state and does not count.
        period = 8'd3; pre_sel = 2'd1; set_duty(20);
        restart();
        repeat (10) @(negedge clk);
        t0 = int'(timer_val);
        o0 = int'(pwm_out);
        clk_en = 1'b0;
        tbad = 0;
        repeat (20) begin
            @(negedge clk);
            if (int'(timer_val) != t0 || int'(pwm_out) != o0) tbad++;
        end
        chk("R9 frozen state", tbad, 0);
        clk_en = 1'b1;
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!period_match && len < 5000);
        chk("R9 remaining length", len, 64 - 10);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule